// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Arbiter and Vector Generator

This block collects the six interrupt sources of a two-channel serial controller. Each channel has three sources: receive, transmit and external/status. The block holds each request as a pending flag and ranks the flags in a fixed order. It drives one active-high interrupt line. When the line is acknowledged, the block moves the winning source into service. A source that is in service holds off every source of equal or lower priority until a reset-highest-in-service command releases it.

The block also builds an 8-bit interrupt vector. It starts from a programmable base and can fold in a 3-bit code that names the source. In status-low mode the code sits in vector bits 3..1. In status-high mode it sits in bits 4..6 with its bit order reversed. There are two read ports. The channel A port returns the plain base. The channel B port always returns the base modified by the highest pending source.

Top module: `sio_irq_arbiter`

## Requirements
- R1: After reset, `irq`, `pend_any`, `pend`, `vec_a`, `vec_b` and `ack_vec` are all zero, the control bits are clear and nothing is in service.
- R2: A pulse on `req_stb[i]` sets `pend[i]` at the next edge only while the registered interrupt-enable bit (written through `ctl_mie`) is 1. With the bit at 0, strobes leave `pend` and `irq` at zero.
- R3: `pend_any` is 1 exactly when `pend` is nonzero. `irq` is 1 when some pending source is not blocked by an in-service source.
- R4: Source index order is `pend[0]`=A receive, [1]=A transmit, [2]=A external/status, [3]=B receive, [4]=B transmit, [5]=B external/status. A lower index has higher priority.
- R5: The source code is 3 bits. Bit 2 is 1 for channel A and 0 for channel B. The low bits are 00 for transmit, 01 for external/status, and for receive 10, or 11 if the channel's `rx_special` bit (bit 0 = A, bit 1 = B) was 1 with the receive strobe.
- R6: In status-low mode (`ctl_hi`=0), the modified vector is the base with bits 3,2,1 replaced by code bits 2,1,0.
- R7: In status-high mode (`ctl_hi`=1), the modified vector is the base with bits 4,5,6 replaced by code bits 2,1,0 respectively. All other bits come from the base.
- R8: `vec_a` always equals the base vector. `vec_b` equals the base modified by the highest pending source whatever `ctl_vis` is, and equals the base when nothing is pending.
- R9: On `int_ack`, the highest unblocked pending source leaves pending and enters service. From the next cycle, `ack_vec` holds the modified vector if `ctl_vis`=1, otherwise the base.
- R10: While a source is in service, pending sources of equal or lower priority do not raise `irq`. A pending source of higher priority does.
- R11: `rst_ius` clears the in-service flag of the highest-priority source in service only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 6 | Per-source request strobes, index as in R4 |
| rx_special | input | 2 | Receive request is a special condition (bit 0 = A, bit 1 = B) |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_mie | input | 1 | Interrupt enable value |
| ctl_vis | input | 1 | Include source code in the acknowledge vector |
| ctl_hi | input | 1 | Place the code in the high vector field |
| base_we | input | 1 | Write strobe for the base vector |
| base_wdata | input | 8 | Base vector value |
| int_ack | input | 1 | Interrupt acknowledge |
| rst_ius | input | 1 | Reset highest in-service command |
| irq | output | 1 | Interrupt request |
| pend_any | output | 1 | Any source pending |
| pend | output | 6 | Pending flags |
| vec_a | output | 8 | Vector read through channel A |
| vec_b | output | 8 | Vector read through channel B |
| ack_vec | output | 8 | Vector latched on acknowledge |

## Verification
The assertions assume three things about the inputs. A request strobe never lands on a source that is being acknowledged in the same cycle. `int_ack` and `rst_ius` are never raised together. The acknowledge-count property also assumes that no strobe arrives in the acknowledge cycle. The bench meets these assumptions by giving each strobe, acknowledge and command its own cycle, with all other controls held low. Within those rules it sweeps every source, special flag, placement mode and vector-include setting, and all 63 nonzero pending patterns.

// File: rtl/sio_irq_arbiter.sv
module sio_irq_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] req_stb,
  input  logic [1:0] rx_special,
  input  logic       ctl_we,
  input  logic       ctl_mie,
  input  logic       ctl_vis,
  input  logic       ctl_hi,
  input  logic       base_we,
  input  logic [7:0] base_wdata,
  input  logic       int_ack,
  input  logic       rst_ius,
  output logic       irq,
  output logic       pend_any,
  output logic [5:0] pend,
  output logic [7:0] vec_a,
  output logic [7:0] vec_b,
  output logic [7:0] ack_vec
);
  localparam int NSRC = 6;

  logic [NSRC-1:0] pend_q, ius_q, elig, win, top, ius_top;
  logic [1:0]      spec_q;
  logic [7:0]      base_q, ack_q;
  logic            mie_q, vis_q, hi_q;

  function automatic logic [NSRC-1:0] lowest(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = NSRC'(1) << i;
    return r;
  endfunction

  function automatic logic [2:0] code_of(input logic [NSRC-1:0] oh, input logic [1:0] sp);
    logic [2:0] c;
    c = '0;
    for (int i = 0; i < NSRC; i++)
      if (oh[i]) begin
        c[2] = (i < 3);
        case (i % 3)
          0:       c[1:0] = {1'b1, sp[i / 3]};
          1:       c[1:0] = 2'b00;
          default: c[1:0] = 2'b01;
        endcase
      end
    return c;
  endfunction

  function automatic logic [7:0] modv(input logic [7:0] b, input logic [2:0] c, input logic h);
    return h ? {b[7], c[0], c[1], c[2], b[3:0]} : {b[7:4], c, b[0]};
  endfunction

  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      blk     = blk | ius_q[i];
      elig[i] = pend_q[i] & ~blk;
    end
  end

  assign win     = lowest(elig);
  assign top     = lowest(pend_q);
  assign ius_top = lowest(ius_q);

  assign irq      = |elig;
  assign pend_any = |pend_q;
  assign pend     = pend_q;
  assign vec_a    = base_q;
  assign vec_b    = pend_any ? modv(base_q, code_of(top, spec_q), hi_q) : base_q;
  assign ack_vec  = ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ius_q  <= '0;
      spec_q <= '0;
      base_q <= '0;
      ack_q  <= '0;
      mie_q  <= 1'b0;
      vis_q  <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      if (ctl_we) begin
        mie_q <= ctl_mie;
        vis_q <= ctl_vis;
        hi_q  <= ctl_hi;
      end
      if (base_we) base_q <= base_wdata;
      if (mie_q && req_stb[0]) spec_q[0] <= rx_special[0];
      if (mie_q && req_stb[3]) spec_q[1] <= rx_special[1];
      pend_q <= (pend_q & ~(int_ack ? win : '0)) | (mie_q ? req_stb : '0);
      ius_q  <= (ius_q & ~(rst_ius ? ius_top : '0)) | (int_ack ? win : '0);
      if (int_ack && irq)
        ack_q <= vis_q ? modv(base_q, code_of(win, spec_q), hi_q) : base_q;
    end
  end
endmodule

module sio_irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] req_stb,
  input logic       int_ack,
  input logic       rst_ius,
  input logic       irq,
  input logic       pend_any,
  input logic [5:0] pend,
  input logic [7:0] vec_a,
  input logic [7:0] vec_b,
  input logic       mie_q,
  input logic [5:0] ius_q
);
  // R2
  mie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) != 6'd0) |-> $past(mie_q));
  // R3
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_any);
  // R8
  vec_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_b & 8'h81) == (vec_a & 8'h81));
  // R9
  ack_pops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && irq && !rst_ius && req_stb == 6'd0) |=> $countones(pend) == $countones($past(pend)) - 1);
  // R11
  ius_release_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ius && !int_ack && ius_q != 6'd0) |=> $countones(ius_q) == $countones($past(ius_q)) - 1);
endmodule

bind sio_irq_arbiter sio_irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_stb(req_stb), .int_ack(int_ack), .rst_ius(rst_ius),
  .irq(irq), .pend_any(pend_any), .pend(pend), .vec_a(vec_a), .vec_b(vec_b),
  .mie_q(mie_q), .ius_q(ius_q)
);

// File: tb/sio_irq_arbiter_test.sv
module sio_irq_arbiter_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] req_stb = '0;
  logic [1:0] rx_special = '0;
  logic ctl_we = 0, ctl_mie = 0, ctl_vis = 0, ctl_hi = 0, base_we = 0;
  logic [7:0] base_wdata = '0;
  logic int_ack = 0, rst_ius = 0;
  logic irq, pend_any;
  logic [5:0] pend;
  logic [7:0] vec_a, vec_b, ack_vec;

  int checks = 0, failures = 0;

  sio_irq_arbiter uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic m, input logic v, input logic h);
    ctl_we = 1; ctl_mie = m; ctl_vis = v; ctl_hi = h; tick(); ctl_we = 0;
  endtask

  task automatic set_base(input logic [7:0] b);
    base_we = 1; base_wdata = b; tick(); base_we = 0;
  endtask

  task automatic strobe(input logic [5:0] m);
    req_stb = m; tick(); req_stb = '0;
  endtask

  task automatic ack();
    int_ack = 1; tick(); int_ack = 0;
  endtask

  task automatic release_ius();
    rst_ius = 1; tick(); rst_ius = 0;
  endtask

  function automatic logic [2:0] exp_code(input int i, input logic sp);
    logic [1:0] lo;
    case (i % 3)
      0:       lo = {1'b1, sp};
      1:       lo = 2'b00;
      default: lo = 2'b01;
    endcase
    return {(i < 3) ? 1'b1 : 1'b0, lo};
  endfunction

  function automatic logic [7:0] exp_vec(input logic [7:0] b, input logic [2:0] c, input logic h);
    logic [7:0] r;
    r = b;
    if (h) begin r[4] = c[2]; r[5] = c[1]; r[6] = c[0]; end
    else   begin r[3] = c[2]; r[2] = c[1]; r[1] = c[0]; end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 pend", pend, 0);
    chk("R1 pend_any", pend_any, 0);
    chk("R1 vec_a", vec_a, 0);
    chk("R1 vec_b", vec_b, 0);
    chk("R1 ack_vec", ack_vec, 0);

    // R2 enable off: strobes ignored
    strobe(6'h3f);
    chk("R2 pend gated", pend, 0);
    chk("R2 irq gated", irq, 0);

    // R5 R6 R7 R8 R9 sweep of single sources
    for (int h = 0; h < 2; h++)
      for (int v = 0; v < 2; v++)
        for (int i = 0; i < 6; i++)
          for (int s = 0; s < 2; s++) begin
            logic [7:0] b, mv;
            b = 8'(8'hA5 ^ (i * 37 + s * 91 + v * 13 + h * 7));
            set_ctl(1, v[0], h[0]);
            set_base(b);
            rx_special = {s[0], s[0]};
            strobe(6'(1) << i);
            rx_special = '0;
            mv = exp_vec(b, exp_code(i, s[0]), h[0]);
            chk("R2 pend set", pend, 6'(1) << i);
            chk("R3 irq", irq, 1);
            chk("R3 pend_any", pend_any, 1);
            chk("R8 vec_a base", vec_a, b);
            chk(h ? "R7 vec_b high" : "R6 vec_b low", vec_b, mv);
            ack();
            chk("R9 ack_vec", ack_vec, v ? mv : b);
            chk("R9 pend cleared", pend, 0);
            chk("R8 vec_b idle", vec_b, b);
            release_ius();
          end

    // R4 R10 R11 priority order over all patterns
    set_ctl(1, 1, 0);
    set_base(8'h00);
    for (int p = 1; p < 64; p++) begin
      logic [5:0] rem;
      int first;
      strobe(6'(p));
      first = 0;
      while (!p[first]) first++;
      chk("R4 vec_b top", vec_b, exp_vec(8'h00, exp_code(first, 0), 0));
      rem = 6'(p);
      while (rem != 0) begin
        int lo;
        lo = 0;
        while (!rem[lo]) lo++;
        ack();
        chk("R4 ack order", ack_vec, exp_vec(8'h00, exp_code(lo, 0), 0));
        rem[lo] = 1'b0;
        chk("R10 lower blocked", irq, 0);
        release_ius();
        chk("R11 released", irq, rem != 0);
      end
    end

    // R10 R11 nesting
    strobe(6'b010000);
    ack();
    chk("R10 in service alone", irq, 0);
    strobe(6'b100000);
    chk("R10 lower held off", irq, 0);
    strobe(6'b000010);
    chk("R10 higher passes", irq, 1);
    ack();
    chk("R9 nested vec", ack_vec, exp_vec(8'h00, exp_code(1, 0), 0));
    release_ius();
    strobe(6'b001000);
    chk("R11 highest only", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule